// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers up to 31 external interrupt sources and presents one interrupt line to a CPU. Every source has a 16-bit control register on a simple synchronous register bus. The register holds an enable bit, a two-bit sense mode (rising or falling edge, high or low level), a three-bit priority level and a pending flag. Raw source inputs pass through a two-flop synchroniser. Edge detection then compares the synchronised value with its value one clock earlier.

Pending requests are latched per source. Among sources that are enabled, pending and at a nonzero level, a combinational arbiter picks the highest level, and a tie goes to the lowest source number. The winning source number appears in a status register, next to a fixed vector-base field. The CPU line is high while any such source exists. Software clears an edge request by writing 0 to the pending bit of its control register. Level requests track the input. Two request registers show the pending flags of all sources at once.

Sources are numbered from 1. Source n is input bit `src_i[n-1]`, and its control register is at byte offset 0x100 + 2*(n-1).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all control registers read 0, so every source is disabled, in falling-edge mode and not pending. `irq_o` is low and the status register reads only the vector base.
- R2: Control register fields are: bit 12 enable, bit 8 pending, bits 5:4 sense mode, bits 2:0 level. All other bits read 0. Source n sits at 0x100 + 2*(n-1).
- R3: Sense mode 2'b10 sets pending on a rising input, and mode 2'b00 sets it on a falling input. The opposite transition sets nothing.
- R4: In an edge mode the pending bit stays set after the input returns. Writing the control register with bit 8 = 0 clears it, and writing bit 8 = 1 neither sets nor clears it.
- R5: In mode 2'b11 (high level) or 2'b01 (low level) the pending bit equals whether the input is at its active level. A write of 0 to bit 8 does not clear it while the input stays active.
- R6: `irq_o` is high exactly when some source is enabled, pending and at a nonzero level. A cleared enable or level 0 masks the source.
- R7: Status bits 10:6 hold the number of the winning source: the highest level wins, and a tie goes to the lowest number. The field reads 0 when no source qualifies.
- R8: Status register (offset 0x002) bits 15:12 hold the VEC_BASE parameter, and bits 11 and 5:0 read 0.
- R9: The request register at 0x004 carries in bit j the pending flag of source j (bit 0 is always 0). The register at 0x006 carries in bit j the pending flag of source 16+j. Both are shown regardless of enable or level.
- R10: An input transition becomes pending, and is seen on `irq_o`, on the third rising clock edge after it, not on the second.
- R11: A read strobe (`bus_req_i` high, `bus_we_i` low) loads `bus_rdata_o` at the clock edge with the addressed register. Unmapped addresses read 0, and writes to the status or request registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw source inputs; bit n-1 is source n |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with NUM_SRC = 31 and VEC_BASE = 4'hA. With 31 sources the whole five-bit source field is in use, and source 31 lands in bit 15 of the upper request register. The nonzero vector base keeps its field distinct from the source number. Random rounds drive mixed sense modes, levels and enables over all 31 sources against a bench model. Directed cases cover the exact three-edge latency, the wrong-edge and clear-write behaviour, and arbitration ties.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W    = 3;
  localparam int NUM_W    = 5;   // status source-number field, bits 10:6
  localparam int EN_BIT   = 12;
  localparam int PEND_BIT = 8;
  localparam int SNS_LSB  = 4;

  // bit 1: active polarity (1 = high), bit 0: level sensitive
  typedef enum logic [1:0] {
    SNS_FALL = 2'b00,
    SNS_LOW  = 2'b01,
    SNS_RISE = 2'b10,
    SNS_HIGH = 2'b11
  } sense_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/pic_src_cell.sv
module pic_src_cell
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [15:0]      wdata_i,
  input  logic             cur_i,
  input  logic             prev_i,
  output logic             en_o,
  output logic [1:0]       sense_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             pend_o
);
  logic             en_q, en_d;
  logic [1:0]       sense_q, sense_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             pend_q, pend_d;
  logic             at_active, edge_hit;

  always_comb begin
    en_d    = en_q;
    sense_d = sense_q;
    lvl_d   = lvl_q;
    if (wr_i) begin
      en_d    = wdata_i[EN_BIT];
      sense_d = wdata_i[SNS_LSB+1:SNS_LSB];
      lvl_d   = wdata_i[LVL_W-1:0];
    end
  end

  // pending follows the mode in force after this cycle's write
  assign at_active = (cur_i == sense_d[1]);
  assign edge_hit  = (cur_i != prev_i) && at_active;

  always_comb begin
    if (sense_d[0])                         pend_d = at_active;
    else if (edge_hit)                      pend_d = 1'b1;
    else if (wr_i && !wdata_i[PEND_BIT])    pend_d = 1'b0;
    else                                    pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sense_q <= SNS_FALL;
      lvl_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      sense_q <= sense_d;
      lvl_q   <= lvl_d;
      pend_q  <= pend_d;
    end
  end

  assign en_o    = en_q;
  assign sense_o = sense_q;
  assign lvl_o   = lvl_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input  logic [NUM_SRC-1:0]            elig_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic [NUM_W-1:0]              win_o,
  output logic                          any_o
);
  logic [LVL_W-1:0] best_lvl;
  logic [NUM_W-1:0] best_num;

  // strict compare keeps the lowest number on equal levels
  always_comb begin
    best_lvl = '0;
    best_num = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (elig_i[k] && (lvl_i[k] > best_lvl)) begin
        best_lvl = lvl_i[k];
        best_num = NUM_W'(k + 1);
      end
    end
  end

  assign win_o = best_num;
  assign any_o = |elig_i;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          NUM_SRC  = 31,   // at most 31: five-bit number field
  parameter int          ADDR_W   = 9,
  parameter logic [3:0]  VEC_BASE = 4'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [15:0]        bus_wdata_i,
  output logic [15:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'('h002);
  localparam logic [ADDR_W-1:0] REQ0_ADDR = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] REQ1_ADDR = ADDR_W'('h006);
  localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'('h100);

  logic [NUM_SRC-1:0]            cur_v, prev_v, en_v, pend_v, elig_v;
  logic [NUM_SRC-1:0]            ctrl_hit, wr_hit;
  logic [NUM_SRC-1:0][1:0]       sense_v;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_v;
  logic [NUM_W-1:0]              win_num;
  logic                          any_elig;
  logic                          bus_wr;
  logic [31:0]                   pend_num;
  logic [15:0]                   rd_mux, rdata_q;

  assign bus_wr = bus_req_i & bus_we_i;

  pic_sync #(.W(NUM_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (src_i),
    .cur_o  (cur_v),
    .prev_o (prev_v)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign ctrl_hit[k] = (bus_addr_i == CTRL_BASE + ADDR_W'(2 * k));
    assign wr_hit[k]   = bus_wr & ctrl_hit[k];

    pic_src_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_hit[k]),
      .wdata_i (bus_wdata_i),
      .cur_i   (cur_v[k]),
      .prev_i  (prev_v[k]),
      .en_o    (en_v[k]),
      .sense_o (sense_v[k]),
      .lvl_o   (lvl_v[k]),
      .pend_o  (pend_v[k])
    );

    assign elig_v[k] = en_v[k] & pend_v[k] & (lvl_v[k] != '0);
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .elig_i (elig_v),
    .lvl_i  (lvl_v),
    .win_o  (win_num),
    .any_o  (any_elig)
  );

  assign irq_o = any_elig;

  // bit n of pend_num is source n; bit 0 has no source
  assign pend_num = 32'({pend_v, 1'b0});

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == STS_ADDR)       rd_mux = {VEC_BASE, 1'b0, win_num, 6'b0};
    else if (bus_addr_i == REQ0_ADDR) rd_mux = pend_num[15:0];
    else if (bus_addr_i == REQ1_ADDR) rd_mux = pend_num[31:16];
    else begin
      for (int k = 0; k < NUM_SRC; k++) begin
        if (ctrl_hit[k])
          rd_mux = {3'b0, en_v[k], 3'b0, pend_v[k], 2'b0, sense_v[k], 1'b0, lvl_v[k]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (bus_req_i && !bus_we_i)  rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          irq_i,
  input logic [NUM_W-1:0]              win_i,
  input logic [NUM_SRC-1:0]            en_i,
  input logic [NUM_SRC-1:0]            pend_i,
  input logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input logic [NUM_SRC-1:0][1:0]       sense_i,
  input logic [NUM_SRC-1:0]            cur_i,
  input logic [NUM_SRC-1:0]            wr_i
);
  logic [NUM_W-1:0] widx;
  assign widx = win_i - NUM_W'(1);

  AST_IRQ_HAS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (win_i != '0)); // R6
  AST_IDLE_NUM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> (win_i == '0)); // R7
  AST_WINNER_QUALIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i != '0) |-> (en_i[widx] && pend_i[widx] && (lvl_i[widx] != '0))); // R7

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    AST_NO_HIGHER_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[k] && pend_i[k] && (lvl_i[k] != '0)) |->
        (irq_i && (lvl_i[k] <= lvl_i[widx]))); // R7
    AST_TIE_LOW_NUMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[k] && pend_i[k] && (lvl_i[k] != '0) && (win_i != '0) && (lvl_i[k] == lvl_i[widx])) |->
        (win_i <= NUM_W'(k + 1))); // R7
    AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sense_i[k][0] |-> (pend_i[k] == ($past(cur_i[k]) == sense_i[k][1]))); // R5
    AST_EDGE_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[k][0] && $fell(pend_i[k])) |-> $past(wr_i[k])); // R4
    AST_EDGE_RIGHT_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[k][0] && $rose(pend_i[k])) |-> ($past(cur_i[k]) == sense_i[k][1])); // R3
  end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_o),
  .win_i   (win_num),
  .en_i    (en_v),
  .pend_i  (pend_v),
  .lvl_i   (lvl_v),
  .sense_i (sense_v),
  .cur_i   (cur_v),
  .wr_i    (wr_hit)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int         N  = 31;
  localparam logic [3:0] VB = 4'hA;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [8:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         irq;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(9), .VEC_BASE(VB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit         m_en   [1:N];
  logic [1:0] m_sns  [1:N];
  logic [2:0] m_lvl  [1:N];
  bit         m_pend [1:N];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_n(int n);
    repeat (n) tick();
  endtask

  task automatic bus_write(logic [8:0] a, logic [15:0] d);
    addr = a; wdata = d; req = 1'b1; we = 1'b1;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [8:0] a, output logic [15:0] v);
    addr = a; req = 1'b1; we = 1'b0;
    tick();
    v = rdata; req = 1'b0;
  endtask

  function automatic logic [8:0] ctrl_addr(int n);
    return 9'h100 + 9'(2 * (n - 1));
  endfunction

  function automatic logic [15:0] cfg_word(bit en, logic [1:0] sns, logic [2:0] lvl);
    return {3'b0, en, 3'b0, 1'b0, 2'b0, sns, 1'b0, lvl};
  endfunction

  function automatic logic [15:0] exp_status();
    logic [2:0] bl = 3'd0;
    int bn = 0;
    for (int n = 1; n <= N; n++)
      if (m_en[n] && m_pend[n] && m_lvl[n] != 0 && m_lvl[n] > bl) begin
        bl = m_lvl[n]; bn = n;
      end
    return {VB, 1'b0, 5'(bn), 6'b0};
  endfunction

  function automatic logic [15:0] exp_req(int half);
    logic [15:0] v = '0;
    for (int b = 0; b < 16; b++) begin
      int n = half * 16 + b;
      if (n >= 1 && n <= N) v[b] = m_pend[n];
    end
    return v;
  endfunction

  task automatic check_model(string ph);
    logic [15:0] v, es;
    es = exp_status();
    check({$sformatf("R6 irq %s", ph)}, {15'b0, irq}, {15'b0, es[10:6] != 0});
    bus_read(9'h002, v);
    check({$sformatf("R7 status %s", ph)}, v, es);
    bus_read(9'h004, v);
    check({$sformatf("R9 req0 %s", ph)}, v, exp_req(0));
    bus_read(9'h006, v);
    check({$sformatf("R9 req1 %s", ph)}, v, exp_req(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd24681));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    bus_read(9'h002, v); check("R1 R8 status", v, 16'hA000);
    bus_read(ctrl_addr(1), v); check("R1 ctrl1", v, 16'h0000);
    bus_read(9'h004, v); check("R1 req0", v, 16'h0000);

    // R2 layout: all ones -> only defined fields, pending ignored
    bus_write(ctrl_addr(1), 16'hFFFF);
    wait_n(4);
    bus_read(ctrl_addr(1), v); check("R2 ctrl1 layout", v, 16'h1037);
    bus_write(ctrl_addr(31), 16'h1012);   // low level, level 2, input low
    wait_n(5);
    bus_read(ctrl_addr(31), v); check("R2 R5 ctrl31", v, 16'h1112);
    bus_read(9'h002, v); check("R7 R8 status src31", v, 16'hA7C0);
    bus_read(9'h006, v); check("R9 req1 bit15", v, 16'h8000);
    bus_write(ctrl_addr(31), 16'h0000);
    wait_n(4);
    check("R6 irq after clear", {15'b0, irq}, 16'h0);

    // R10 latency with rising-edge source 2
    bus_write(ctrl_addr(2), 16'h1023);
    src[1] = 1'b1;
    wait_n(2);
    check("R10 not yet after two edges", {15'b0, irq}, 16'h0);
    tick();
    check("R10 R3 pending on third edge", {15'b0, irq}, 16'h1);

    // R3 falling input does not set a rising-edge source
    src[1] = 1'b0;
    wait_n(5);
    bus_write(ctrl_addr(2), 16'h1023);
    wait_n(5);
    check("R3 wrong edge irq", {15'b0, irq}, 16'h0);
    bus_read(ctrl_addr(2), v); check("R3 wrong edge ctrl2", v, 16'h1023);

    // R3 falling-edge source 3
    src[2] = 1'b1;
    wait_n(5);
    bus_write(ctrl_addr(3), 16'h1004);
    wait_n(3);
    bus_read(ctrl_addr(3), v); check("R3 rise ignored in fall mode", v, 16'h1004);
    src[2] = 1'b0;
    wait_n(5);
    bus_read(ctrl_addr(3), v); check("R3 fall sets", v, 16'h1104);

    // R4 hold and clear
    src[2] = 1'b1;
    wait_n(5);
    bus_read(ctrl_addr(3), v); check("R4 held after return", v, 16'h1104);
    bus_write(ctrl_addr(3), 16'h1104);
    wait_n(2);
    bus_read(ctrl_addr(3), v); check("R4 write one keeps", v, 16'h1104);
    bus_write(ctrl_addr(3), 16'h1004);
    wait_n(2);
    bus_read(ctrl_addr(3), v); check("R4 write zero clears", v, 16'h1004);
    check("R4 irq after clear", {15'b0, irq}, 16'h0);

    // R5 high level source 4
    bus_write(ctrl_addr(4), 16'h1035);
    src[3] = 1'b1;
    wait_n(5);
    bus_read(ctrl_addr(4), v); check("R5 level pending", v, 16'h1135);
    bus_write(ctrl_addr(4), 16'h1035);
    wait_n(2);
    bus_read(ctrl_addr(4), v); check("R5 clear ignored", v, 16'h1135);
    src[3] = 1'b0;
    wait_n(5);
    bus_read(ctrl_addr(4), v); check("R5 level released", v, 16'h1035);
    check("R5 irq released", {15'b0, irq}, 16'h0);

    // R6 masking by enable and by level 0
    bus_write(ctrl_addr(4), 16'h0035);
    src[3] = 1'b1;
    wait_n(5);
    check("R6 disabled source", {15'b0, irq}, 16'h0);
    bus_read(9'h004, v); check("R9 pending shown while disabled", v, 16'h0010);
    bus_write(ctrl_addr(4), 16'h1030);
    wait_n(3);
    check("R6 level zero", {15'b0, irq}, 16'h0);

    // R7 tie and level order
    bus_write(ctrl_addr(5), 16'h1033);
    bus_write(ctrl_addr(6), 16'h1033);
    src[4] = 1'b1; src[5] = 1'b1;
    wait_n(5);
    bus_read(9'h002, v); check("R7 tie lowest number", v, 16'hA140);
    bus_write(ctrl_addr(6), 16'h1036);
    wait_n(2);
    bus_read(9'h002, v); check("R7 higher level wins", v, 16'hA180);

    // R11 read-only and unmapped
    bus_write(9'h002, 16'hFFFF);
    bus_write(9'h004, 16'hFFFF);
    wait_n(2);
    bus_read(9'h002, v); check("R11 status write ignored", v, 16'hA180);
    bus_read(9'h004, v); check("R11 req write ignored", v, 16'h0070);
    bus_read(9'h00A, v); check("R11 unmapped", v, 16'h0000);

    // random rounds against the model
    for (int r = 0; r < 40; r++) begin
      for (int n = 1; n <= N; n++) begin
        m_en[n]  = ($urandom % 4) != 0;
        m_sns[n] = 2'($urandom % 4);
        m_lvl[n] = 3'($urandom % 8);
        src[n-1] = m_sns[n][0] ? 1'b0 : ~m_sns[n][1];
      end
      wait_n(5);
      for (int n = 1; n <= N; n++)
        bus_write(ctrl_addr(n), cfg_word(m_en[n], m_sns[n], m_lvl[n]));
      for (int n = 1; n <= N; n++) begin
        bit b = 1'($urandom % 2);
        if (m_sns[n][0]) begin
          src[n-1] = b; m_pend[n] = (b == m_sns[n][1]);
        end else begin
          if (b) src[n-1] = m_sns[n][1];
          m_pend[n] = b;
        end
      end
      wait_n(5);
      check_model("R3 R5 phase a");
      for (int n = 1; n <= N; n++) begin
        bit b = 1'($urandom % 2);
        if (m_sns[n][0]) begin
          src[n-1] = b; m_pend[n] = (b == m_sns[n][1]);
        end else if (b) begin
          src[n-1] = ~m_sns[n][1];   // pending must hold
        end
      end
      wait_n(5);
      check_model("R4 R5 phase b");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule